// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple internal request bus and an external asynchronous static RAM of 131072 bytes (17-bit address, 8-bit data). A requester pulses `req` for one clock cycle with the direction, address and write data. The controller then drives the memory's strobes for a number of system clock cycles that is derived from nanosecond limits. It reports completion with a one-cycle `rdy` pulse.

The memory has two chip-select pins of opposite polarity, a write strobe, an output-enable strobe and a shared data bus. The data bus is split here into an outgoing value, an incoming value and a drive enable, for a pad cell outside this block. Every timing limit is a parameter in nanoseconds. Each is turned into a cycle count by ceiling division by the clock period. A read is always followed by a quiet turnaround window, so the controller never drives data while the memory may still be driving it.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ram_en_n`=1, `ram_en`=0, `ram_wr_n`=1, `ram_rd_n`=1, `ram_dq_oe`=0 and `rdy`=0.
- R2: The memory is selected (`ram_en_n`=0 and `ram_en`=1) in exactly the cycles where a read or write strobe is active. At all other times both select pins are inactive.
- R3: An accepted read holds `ram_rd_n`=0 and `ram_wr_n`=1 for RD = ceil(max(tRC, tAA, tOE) / Tclk) cycles. A read and a write strobe are never low together.
- R4: An accepted write holds `ram_wr_n`=0 and `ram_rd_n`=1 for WR = ceil(max(tWC, tWP, tAW, tDW) / Tclk) cycles. `ram_dq_oe` is 1 only while `ram_wr_n`=0, and `ram_dq_o` then equals the request's write data.
- R5: From the accepting edge until the strobes are released, `ram_addr` equals the request address and does not change.
- R6: `rdata` takes the value on `ram_dq_i` in the last cycle of the read window. It keeps that value through later writes until the next read completes.
- R7: After a read, all strobes and the data drive stay inactive for TA = max(1, ceil(tHZ / Tclk)) cycles before the controller becomes idle again.
- R8: `rdy` is a single-cycle pulse. It rises RD+TA edges after the accepting edge for a read and WR edges after it for a write, and the controller is idle in that cycle.
- R9: A `req` pulse that arrives while an access is in progress is ignored: it causes no strobe and no memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle access request, taken only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Data from the most recent read |
| ram_addr | output | 17 | Memory address |
| ram_dq_o | output | 8 | Data to drive onto the memory bus |
| ram_dq_i | input | 8 | Data seen on the memory bus |
| ram_dq_oe | output | 1 | Drive enable for the data bus pads |
| ram_en_n | output | 1 | Active-low chip select |
| ram_en | output | 1 | Active-high chip select |
| ram_wr_n | output | 1 | Active-low write strobe |
| ram_rd_n | output | 1 | Active-low output enable |

## Verification
The bench walks a single one through all 17 address bits and also uses the all-zeros and all-ones addresses, with data computed from the address. A wrong bit or a stuck address line therefore shows up as a read-back mismatch. It runs back-to-back writes, back-to-back reads and alternating write/read pairs. These separate the write-to-read, read-to-read and read-to-write orderings, and the last of these is where the turnaround window must appear in the measured latency. A request injected in the middle of a read separates a controller that ignores busy-time requests from one that starts a spurious write, which a later read of the target address would reveal.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_TURN  = 2'd3
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int RD_CYC = 7,
  parameter int WR_CYC = 7,
  parameter int TA_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              t_zero,
  output logic              t_load,
  output logic [CNT_W-1:0]  t_val,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_dq_oe,
  output logic              ram_en_n,
  output logic              ram_en,
  output logic              ram_wr_n,
  output logic              ram_rd_n
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  seq_state_t state;
  logic       take;

  assign take = (state == ST_IDLE) && req;

  // The timer starts a window on acceptance and again when a read hands over to turnaround
  always_comb begin
    t_load = take || ((state == ST_READ) && t_zero);
    if (state == ST_IDLE) begin
      t_val = req_we ? WR_LOAD : RD_LOAD;
    end else begin
      t_val = TA_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rdy       <= 1'b0;
      rdata     <= '0;
      ram_addr  <= '0;
      ram_dq_o  <= '0;
      ram_dq_oe <= 1'b0;
      ram_en_n  <= 1'b1;
      ram_en    <= 1'b0;
      ram_wr_n  <= 1'b1;
      ram_rd_n  <= 1'b1;
    end else begin
      rdy <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            ram_addr <= req_addr;
            ram_en_n <= 1'b0;
            ram_en   <= 1'b1;
            if (req_we) begin
              ram_wr_n  <= 1'b0;
              ram_dq_oe <= 1'b1;
              ram_dq_o  <= req_wdata;
              state     <= ST_WRITE;
            end else begin
              ram_rd_n <= 1'b0;
              state    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (t_zero) begin
            rdata    <= ram_dq_i;
            ram_rd_n <= 1'b1;
            ram_en_n <= 1'b1;
            ram_en   <= 1'b0;
            state    <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (t_zero) begin
            rdy   <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (t_zero) begin
            ram_wr_n  <= 1'b1;
            ram_dq_oe <= 1'b0;
            ram_en_n  <= 1'b1;
            ram_en    <= 1'b0;
            rdy       <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: the bus is driven only under an active write strobe
  p_drive_under_wstb_r4: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> !ram_wr_n);

  // R3: read and write strobes are mutually exclusive
  p_rd_wr_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(!ram_rd_n && !ram_wr_n));

  // R2: any strobe implies both selects active
  p_strobe_selected_r2: assert property (@(posedge clk) disable iff (rst)
    (!ram_rd_n || !ram_wr_n) |-> (!ram_en_n && ram_en));

  // R5: address frozen while selected
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ram_en_n && $past(!ram_en_n)) |-> $stable(ram_addr));

  // R8: completion is a single-cycle pulse
  p_rdy_single_r8: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

  // R7: the cycle after a read ends never drives the bus
  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_rd_n) |=> !ram_dq_oe);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 40,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 50,
  parameter int T_AW_NS  = 60,
  parameter int T_DW_NS  = 30,
  parameter int T_HZ_NS  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_dq_oe,
  output logic              ram_en_n,
  output logic              ram_en,
  output logic              ram_wr_n,
  output logic              ram_rd_n
);

  localparam int RD_CYC  = ceil_div(max2(T_RC_NS, max2(T_AA_NS, T_OE_NS)), CLK_NS);
  localparam int WR_CYC  = ceil_div(max2(max2(T_WC_NS, T_WP_NS), max2(T_AW_NS, T_DW_NS)), CLK_NS);
  localparam int TA_CYC  = max2(1, ceil_div(T_HZ_NS, CLK_NS));
  localparam int MAX_CYC = max2(RD_CYC, max2(WR_CYC, TA_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             t_load;
  logic             t_zero;
  logic [CNT_W-1:0] t_val;

  sram_wait_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  sram_ctrl_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .t_zero    (t_zero),
    .t_load    (t_load),
    .t_val     (t_val),
    .rdy       (rdy),
    .rdata     (rdata),
    .ram_addr  (ram_addr),
    .ram_dq_o  (ram_dq_o),
    .ram_dq_i  (ram_dq_i),
    .ram_dq_oe (ram_dq_oe),
    .ram_en_n  (ram_en_n),
    .ram_en    (ram_en),
    .ram_wr_n  (ram_wr_n),
    .ram_rd_n  (ram_rd_n)
  );

endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;

  localparam int CLK_NS = 8;
  localparam int RD = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WR = (70 + CLK_NS - 1) / CLK_NS;
  localparam int TA = (30 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic rdy;
  logic [7:0] rdata;
  logic [16:0] ram_addr;
  logic [7:0] ram_dq_o;
  logic [7:0] ram_dq_i = 8'h00;
  logic ram_dq_oe, ram_en_n, ram_en, ram_wr_n, ram_rd_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] ram_mem [int];
  logic [7:0] exp_mem [int];

  always #4 clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata), .ram_addr(ram_addr),
    .ram_dq_o(ram_dq_o), .ram_dq_i(ram_dq_i), .ram_dq_oe(ram_dq_oe),
    .ram_en_n(ram_en_n), .ram_en(ram_en), .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n)
  );

  // Memory model: writes during select + write strobe, read data driven when output enabled
  always @(negedge clk) begin
    if (!ram_en_n && ram_en && !ram_wr_n && ram_dq_oe) ram_mem[int'(ram_addr)] = ram_dq_o;
    if (!ram_en_n && ram_en && !ram_rd_n && ram_wr_n)
      ram_dq_i = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'hEE;
    else
      ram_dq_i = 8'h00;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
  endfunction

  task automatic access(input logic we, input logic [16:0] a, input logic [7:0] d,
                        input bit inject, input logic [16:0] inj_a);
    int n = 0, rlow = 0, wlow = 0, bad = 0;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (inject && n == 2) begin
        req = 1'b1; req_we = 1'b1; req_addr = inj_a; req_wdata = 8'hC3;
      end else begin
        req = 1'b0;
      end
      if (!ram_rd_n) rlow++;
      if (!ram_wr_n) wlow++;
      if (!ram_rd_n || !ram_wr_n) begin
        if (ram_en_n || !ram_en) bad++;
        if (ram_addr != a) bad++;
      end else if (!ram_en_n || ram_en) bad++;
      if (ram_dq_oe && (ram_wr_n || ram_dq_o != d)) bad++;
      if (rdy || n > 200) break;
      @(posedge clk);
      n++;
    end
    if (we) begin
      chk("R4 write strobe cycles", wlow, WR);
      chk("R4 no read strobe in write", rlow, 0);
      chk("R8 write latency", n, WR);
      exp_mem[int'(a)] = d;
    end else begin
      chk("R3 read strobe cycles", rlow, RD);
      chk(inject ? "R9 no write from busy req" : "R3 no write in read", wlow, 0);
      chk("R8 R7 read latency incl turnaround", n, RD + TA);
      chk("R6 read data", int'(rdata),
          exp_mem.exists(int'(a)) ? int'(exp_mem[int'(a)]) : 32'hEE);
    end
    chk("R2 R5 select/address/drive consistency", bad, 0);
    @(negedge clk);
    chk("R8 rdy single pulse", int'(rdy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [16:0] addrs [19];
    logic [7:0]  held;
    addrs[0] = 17'h00000;
    addrs[1] = 17'h1FFFF;
    for (int i = 0; i < 17; i++) addrs[i + 2] = 17'(1) << i;

    repeat (3) @(negedge clk);
    chk("R1 en_n in reset", int'(ram_en_n), 1);
    chk("R1 en in reset", int'(ram_en), 0);
    chk("R1 wr_n in reset", int'(ram_wr_n), 1);
    chk("R1 rd_n in reset", int'(ram_rd_n), 1);
    chk("R1 dq_oe in reset", int'(ram_dq_oe), 0);
    chk("R1 rdy in reset", int'(rdy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'({ram_en_n, ram_en, ram_wr_n, ram_rd_n, ram_dq_oe}), 5'b10110);

    for (int i = 0; i < 19; i++) access(1'b1, addrs[i], pat(addrs[i]), 1'b0, '0);
    for (int i = 0; i < 19; i++) access(1'b0, addrs[i], 8'h00, 1'b0, '0);

    held = rdata;
    access(1'b1, addrs[5], 8'h3C, 1'b0, '0);
    chk("R6 rdata held across write", int'(rdata), int'(held));

    for (int i = 0; i < 19; i++) begin
      access(1'b1, addrs[i], ~pat(addrs[i]), 1'b0, '0);
      access(1'b0, addrs[i], 8'h00, 1'b0, '0);
    end

    access(1'b0, addrs[3], 8'h00, 1'b1, addrs[4]);
    repeat (2) @(negedge clk);
    access(1'b0, addrs[4], 8'h00, 1'b0, '0);
    chk("R9 target unchanged after busy req", int'(rdata), int'(exp_mem[int'(addrs[4])]));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule